// File: doc/BRIEF.md
# Sixteen-Line Interrupt Aggregator with Strobe-Controlled Enables

This block gathers sixteen peripheral interrupt requests into one host interrupt. Each raw request line is first brought into the clock domain through a flop chain; a rising level on a line then records a pending event in a latched status register. The host sees a single active-high level interrupt for as long as some line is both pending and enabled.

Software reaches the block through a small synchronous register port with byte offsets and a 16-bit data path. Bit n of every register always refers to line n. The per-line enable mask has no direct write. It is changed only by writing ones to a "set enables" address or to a "clear enables" address. Pending bits are acknowledged by writing ones to the status address. A separate read-only view shows the synchronised live levels of the lines. In a typical board, lines 10 and 11 carry the requests of two external serial channels, and a driver reads status AND mask to find the lines it must service.

Top module: `irq_expander`

## Requirements
- R1: After reset every pending bit and every enable bit is 0, `host_irq` is 0, and all four decoded registers read 0 while the lines are low.
- R2: A 0-to-1 change on `irq_lines[n]`, held stable, sets pending bit n at the third rising clock edge after the change: it still reads 0 after two edges. A line that stays high or falls sets nothing.
- R3: Writing to offset 0x16 clears each pending bit whose data bit is 1. Data bits of 0 leave their pending bits unchanged.
- R4: When a write to 0x16 clears bit n in the same cycle that a new edge on line n sets it, the bit ends up set.
- R5: Writing to offset 0x1A sets each enable bit whose data bit is 1. The other enable bits keep their values.
- R6: Writing to offset 0x1C clears each enable bit whose data bit is 1. The other enable bits keep their values.
- R7: `reg_rdata` is combinational from `reg_addr`. Offset 0x16 returns the pending bits. Offsets 0x1A and 0x1C both return the enable mask.
- R8: Offset 0x18 returns the line levels as seen after two clock edges of synchronisation. Reading it changes no state.
- R9: `host_irq` is 1 exactly when (pending AND enable) is nonzero. It changes in the same cycle as the registers do.
- R10: Any other offset, odd offsets included, reads 0. Writes to it change neither the pending nor the enable bits.
- R11: Writing 0xFFFF to 0x1C and then 0xFFFF to 0x16, with no new line edge, leaves every line disabled, nothing pending and `host_irq` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Byte offset of the access |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 16 | Write data, bit n for line n |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| irq_lines | input | 16 | Raw peripheral request lines, asynchronous |
| host_irq | output | 1 | Active-high level interrupt to the host |

## Verification
On every cycle the assertions check the following. A set-enable write leaves its written bits at 1. A clear-enable write leaves them at 0. The mask holds when neither strobe fires. A detected edge always lands in the pending register, even when a clear hits the same bit. No pending bit appears without an edge. The exact three-edge latency from a raw line to its pending bit, the result of the initialisation sequence, and the zero reads and ignored writes at undecoded offsets can only be shown by the bench's scenarios. The same holds for the agreement of every read with the model under random traffic.

// File: rtl/irqx_pkg.sv
package irqx_pkg;
    localparam int unsigned LINES       = 16;
    localparam int unsigned ADDR_W      = 8;
    localparam int unsigned SYNC_STAGES = 2;

    localparam logic [ADDR_W-1:0] OFS_PEND  = 8'h16;
    localparam logic [ADDR_W-1:0] OFS_LIVE  = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_ENSET = 8'h1A;
    localparam logic [ADDR_W-1:0] OFS_ENCLR = 8'h1C;
endpackage

// File: rtl/irqx_sync.sv
module irqx_sync #(
    parameter int unsigned N      = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] level_o,
    output logic [N-1:0] rise_o
);
    localparam int unsigned LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][N-1:0] stg;
        logic [N-1:0]             prev;
    } sync_st_t;

    sync_st_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.stg[0] = raw_i;
        for (int i = 1; i < STAGES; i++) begin
            s_d.stg[i] = s_q.stg[i-1];
        end
        s_d.prev = s_q.stg[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign level_o = s_q.stg[LAST];
    assign rise_o  = s_q.stg[LAST] & ~s_q.prev;

    // A detected rise cannot repeat on the next cycle for the same line (R2)
    p_rise_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/irqx_core.sv
module irqx_core #(
    parameter int unsigned N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] rise_i,
    input  logic         ack_i,
    input  logic         en_set_i,
    input  logic         en_clr_i,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] pend_o,
    output logic [N-1:0] en_o,
    output logic         host_irq_o
);
    typedef struct packed {
        logic [N-1:0] pend;
        logic [N-1:0] en;
    } core_st_t;

    core_st_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (ack_i) c_d.pend = c_q.pend & ~wdata_i;
        c_d.pend = c_d.pend | rise_i;
        if (en_set_i) c_d.en = c_q.en | wdata_i;
        else if (en_clr_i) c_d.en = c_q.en & ~wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign pend_o     = c_q.pend;
    assign en_o       = c_q.en;
    assign host_irq_o = |(c_q.pend & c_q.en);

    p_set_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
        en_set_i |=> ((en_o & $past(wdata_i)) == $past(wdata_i)));

    p_clr_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
        en_clr_i |=> ((en_o & $past(wdata_i)) == '0));

    p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_set_i && !en_clr_i) |=> $stable(en_o));

    p_edge_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i != '0) |=> ((pend_o & $past(rise_i)) == $past(rise_i)));

    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i == '0) |=> ((pend_o & ~$past(pend_o)) == '0));
endmodule

// File: rtl/irq_expander.sv
module irq_expander
    import irqx_pkg::*;
#(
    parameter int unsigned NL = LINES,
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned SS = SYNC_STAGES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_wr,
    input  logic [NL-1:0] reg_wdata,
    output logic [NL-1:0] reg_rdata,
    input  logic [NL-1:0] irq_lines,
    output logic          host_irq
);
    logic [NL-1:0] level, rise, pend, en;
    logic          ack, en_set, en_clr;

    irqx_sync #(.N(NL), .STAGES(SS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_i   (irq_lines),
        .level_o (level),
        .rise_o  (rise)
    );

    assign ack    = reg_wr && (reg_addr == AW'(OFS_PEND));
    assign en_set = reg_wr && (reg_addr == AW'(OFS_ENSET));
    assign en_clr = reg_wr && (reg_addr == AW'(OFS_ENCLR));

    irqx_core #(.N(NL)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_i     (rise),
        .ack_i      (ack),
        .en_set_i   (en_set),
        .en_clr_i   (en_clr),
        .wdata_i    (reg_wdata),
        .pend_o     (pend),
        .en_o       (en),
        .host_irq_o (host_irq)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == AW'(OFS_PEND))       reg_rdata = pend;
        else if (reg_addr == AW'(OFS_LIVE))  reg_rdata = level;
        else if (reg_addr == AW'(OFS_ENSET)) reg_rdata = en;
        else if (reg_addr == AW'(OFS_ENCLR)) reg_rdata = en;
    end

    // Level output must only rise when some enable is set (R9)
    p_irq_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> (en != '0 && pend != '0));
endmodule

// File: tb/irq_expander_bench.sv
`timescale 1ns/1ps
module irq_expander_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic [15:0] irq_lines = 16'h0;
    logic        host_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [15:0] last_rd;
    logic [15:0] m_pend = 0, m_en = 0, m_s1 = 0, m_s2 = 0, m_prev = 0;

    always #2.5 clk = ~clk;

    irq_expander u_irq_expander (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_lines(irq_lines), .host_irq(host_irq)
    );

    function automatic logic [15:0] exp_read(logic [7:0] a);
        case (a)
            8'h16:        return m_pend;
            8'h18:        return m_s2;
            8'h1A, 8'h1C: return m_en;
            default:      return 16'h0;
        endcase
    endfunction

    function automatic string tag_of(logic [7:0] a);
        case (a)
            8'h16:        return "R3";
            8'h18:        return "R8";
            8'h1A, 8'h1C: return "R7";
            default:      return "R10";
        endcase
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(bit wr, logic [7:0] a, logic [15:0] wd, logic [15:0] ln);
        logic [15:0] edg;
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = wd; irq_lines = ln;
        #1;
        last_rd = reg_rdata;
        check(tag_of(a), reg_rdata, exp_read(a));
        check("R9", {15'h0, host_irq}, {15'h0, |(m_pend & m_en)});
        @(posedge clk);
        edg = m_s2 & ~m_prev;
        if (wr && a == 8'h16) m_pend = (m_pend & ~wd) | edg;
        else                  m_pend = m_pend | edg;
        if (wr && a == 8'h1A) m_en = m_en | wd;
        if (wr && a == 8'h1C) m_en = m_en & ~wd;
        m_prev = m_s2; m_s2 = m_s1; m_s1 = ln;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] ln;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state
        check("R1", {15'h0, host_irq}, 16'h0);
        step(0, 8'h16, 0, 0); check("R1", last_rd, 16'h0);
        step(0, 8'h18, 0, 0); check("R1", last_rd, 16'h0);
        step(0, 8'h1A, 0, 0); check("R1", last_rd, 16'h0);
        step(0, 8'h1C, 0, 0); check("R1", last_rd, 16'h0);

        // R2: latency of three edges
        step(0, 8'h16, 0, 16'h0020);
        step(0, 8'h16, 0, 16'h0020);
        step(0, 8'h16, 0, 16'h0020); check("R2", last_rd, 16'h0000);
        step(0, 8'h16, 0, 16'h0020); check("R2", last_rd, 16'h0020);
        check("R9", {15'h0, host_irq}, 16'h0);

        // R5, R7: enable through set strobe
        step(1, 8'h1A, 16'h0020, 16'h0020);
        step(0, 8'h1A, 0, 16'h0020); check("R5", last_rd, 16'h0020);
        check("R9", {15'h0, host_irq}, 16'h1);
        step(0, 8'h1C, 0, 16'h0020); check("R7", last_rd, 16'h0020);

        // R3: write-one-to-clear, zeros inert
        step(1, 8'h16, 16'h0000, 16'h0020);
        step(1, 8'h16, 16'hFFDF, 16'h0020);
        step(0, 8'h16, 0, 16'h0020); check("R3", last_rd, 16'h0020);
        step(1, 8'h16, 16'h0020, 16'h0020);
        step(0, 8'h16, 0, 16'h0020); check("R3", last_rd, 16'h0000);
        check("R9", {15'h0, host_irq}, 16'h0);

        // R8: live view, and a falling line sets nothing (R2)
        step(0, 8'h18, 0, 16'h0020); check("R8", last_rd, 16'h0020);
        step(0, 8'h18, 0, 16'h0000);
        step(0, 8'h18, 0, 16'h0000);
        step(0, 8'h18, 0, 16'h0000); check("R8", last_rd, 16'h0000);
        step(0, 8'h16, 0, 16'h0000); check("R2", last_rd, 16'h0000);

        // R6: clear strobe touches only its ones
        step(1, 8'h1A, 16'hFFFF, 0);
        step(1, 8'h1C, 16'h00F0, 0);
        step(0, 8'h1A, 0, 0); check("R6", last_rd, 16'hFF0F);

        // R4: clear and new edge in the same cycle
        step(0, 8'h16, 0, 16'h0080);
        step(0, 8'h16, 0, 16'h0080);
        step(1, 8'h16, 16'h0080, 16'h0080);
        step(0, 8'h16, 0, 16'h0080); check("R4", last_rd & 16'h0080, 16'h0080);

        // R10: undecoded offsets
        step(1, 8'h17, 16'hFFFF, 16'h0080); check("R10", last_rd, 16'h0000);
        step(1, 8'h1E, 16'hFFFF, 16'h0080);
        step(1, 8'h14, 16'h0000, 16'h0080);
        step(1, 8'h00, 16'hFFFF, 16'h0080); check("R10", last_rd, 16'h0000);
        step(0, 8'h1A, 0, 16'h0080); check("R10", last_rd, 16'hFF0F);
        step(0, 8'h16, 0, 16'h0080); check("R10", last_rd, 16'h0080);

        // R11: initialisation sequence
        step(1, 8'h1C, 16'hFFFF, 16'h0080);
        step(1, 8'h16, 16'hFFFF, 16'h0080);
        step(0, 8'h1A, 0, 16'h0080); check("R11", last_rd, 16'h0000);
        step(0, 8'h16, 0, 16'h0080); check("R11", last_rd, 16'h0000);
        check("R11", {15'h0, host_irq}, 16'h0);

        // Random traffic against the model
        ln = 16'h0080;
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] a;
            int sel;
            if ($urandom_range(0, 3) == 0) ln = ln ^ (16'h1 << $urandom_range(0, 15));
            sel = $urandom_range(0, 4);
            case (sel)
                0: a = 8'h16;
                1: a = 8'h18;
                2: a = 8'h1A;
                3: a = 8'h1C;
                default: a = 8'($urandom_range(0, 31));
            endcase
            step(bit'($urandom_range(0, 1)), a, 16'($urandom), ln);
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule